// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block is a small register-mapped mailbox between a host bus and an embedded display microcontroller. The host writes a 32-bit argument word and a 16-bit command word (an opcode byte plus a parameter byte, for example a pipe index). It then rings a doorbell by writing 1 to bit 0 of the control register. The doorbell bit drives the interrupt request toward the microcontroller and also serves as the busy flag. The host polls it and may issue the next command only once it reads back 0.

When the doorbell is accepted, the command and argument are copied into shadow registers. The microcontroller side reads them from there, so later host writes cannot disturb a pending command. The block also decodes the pending opcode into one-hot flags: pipe select, adaptive brightness level, backlight level, or unknown. The microcontroller clears the doorbell with a single-cycle acknowledge pulse. A programmable cycle limit raises a sticky timeout bit when the acknowledge is late.

Top module: `host_mcu_mailbox`

## Requirements
- R1: After reset, the doorbell and timeout bits are 0, the argument and command registers read 0, the shadow outputs and all decode flags are 0, and the limit register holds DEF_LIMIT (1024).
- R2: The host register map is: address 0 = argument word (32 bits); address 1 = command word, opcode in bits [7:0] and parameter in bits [15:8], upper bits read 0; address 2 = control, doorbell in bit 0 and timeout in bit 1; address 3 = timeout limit in bits [15:0]. Reads return the current value combinationally.
- R3: A write to address 2 with bit 0 = 1 while the doorbell is 0 sets the doorbell on the next clock edge. `mcuIrq` equals the doorbell bit.
- R4: An accepted doorbell copies the argument and command registers into the shadow outputs `mcuData`, `mcuOpcode` and `mcuParam`. The shadows change at no other time, so host writes made while pending do not reach them.
- R5: While the doorbell is 1, a further doorbell write is ignored: no relatch, and no change to timeout or counter. Writing 0 to bit 0 never clears the doorbell.
- R6: An `mcuAck` pulse while the doorbell is 1 clears it on the next edge. An `mcuAck` while the doorbell is 0 has no effect.
- R7: While the doorbell is 1, exactly one flag is set: `opPipeSel` for opcode 0x66, `opAdaptLevel` for 0x65, `opBacklight` for 0x67, or `opUnknown` for any other value. While the doorbell is 0, all four flags are 0.
- R8: With a nonzero limit L, the timeout bit sets on the edge that completes L cycles of doorbell high without acknowledge. It stays set after the acknowledge and clears only when the next doorbell is accepted. A limit of 0 disables the timeout.
- R9: `mcuParam` carries command byte 1, for example the pipe index of a pipe-select command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for hostAddr |
| mcuAck | input | 1 | Single-cycle acknowledge from the microcontroller |
| mcuIrq | output | 1 | Interrupt request (doorbell) |
| mcuOpcode | output | 8 | Latched opcode |
| mcuParam | output | 8 | Latched parameter byte |
| mcuData | output | 32 | Latched argument word |
| opPipeSel | output | 1 | Pending opcode is pipe select |
| opAdaptLevel | output | 1 | Pending opcode is adaptive brightness level |
| opBacklight | output | 1 | Pending opcode is backlight level |
| opUnknown | output | 1 | Pending opcode is not recognised |

## Verification
A wrong doorbell state shows at once on `mcuIrq` and on bit 0 of the control read, in the cycle after the ring or acknowledge edge. A shadow that relatches at the wrong time changes `mcuData`, `mcuOpcode` or `mcuParam` one edge after the offending host write. An off-by-one in the wait counter moves the timeout bit by exactly one cycle, so the reference model has to track the cycle count precisely. Decode faults appear as a wrong flag, or more than one flag, in the same cycle the shadow opcode is visible.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OP_PIPE_SEL   = 8'h66;
  localparam logic [7:0] OP_ADAPT_LVL  = 8'h65;
  localparam logic [7:0] OP_BL_LVL     = 8'h67;

  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_CMD   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_LIMIT = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic latchShadow;  // doorbell accepted this cycle
    logic pending;      // doorbell currently set
  } mbxStrobe_t;

  typedef struct packed {
    logic pipeSel;
    logic adaptLvl;
    logic blLvl;
    logic unknown;
  } opFlags_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [1:0]       hostAddr,
  input  logic [CNT_W-1:0] wrLow,
  input  logic             mcuAck,
  output mbxStrobe_t       strobe,
  output logic             timeoutFlag,
  output logic [CNT_W-1:0] limitReg
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(DEF_LIMIT);

  logic             bell;
  logic [CNT_W-1:0] waitCnt;
  logic             wrCtrl, ringAccept, ackAccept;

  assign wrCtrl     = hostWrEn && (hostAddr == ADDR_CTRL);
  assign ringAccept = wrCtrl && wrLow[0] && !bell;
  assign ackAccept  = bell && mcuAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bell        <= 1'b0;
      timeoutFlag <= 1'b0;
      waitCnt     <= '0;
      limitReg    <= LIMIT_RST;
    end else begin
      if (hostWrEn && hostAddr == ADDR_LIMIT) limitReg <= wrLow;
      if (ackAccept) begin
        bell <= 1'b0;
      end else if (ringAccept) begin
        bell        <= 1'b1;
        timeoutFlag <= 1'b0;
        waitCnt     <= '0;
      end else if (bell && waitCnt != CNT_MAX) begin
        waitCnt <= waitCnt + 1'b1;
        if (limitReg != '0 && (waitCnt + 1'b1) == limitReg) timeoutFlag <= 1'b1;
      end
    end
  end

  assign strobe.latchShadow = ringAccept;
  assign strobe.pending     = bell;

  AST_RING_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_CTRL && wrLow[0] && !strobe.pending) |=> strobe.pending); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pending && mcuAck) |=> !strobe.pending); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pending && !(hostWrEn && hostAddr == ADDR_CTRL && wrLow[0])) |=> !strobe.pending); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pending && !mcuAck) |=> strobe.pending); // R5
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !(hostWrEn && hostAddr == ADDR_CTRL && wrLow[0] && !strobe.pending))
      |=> timeoutFlag); // R8
  AST_NO_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!timeoutFlag && !strobe.pending) |=> !timeoutFlag); // R8
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       pending,
  output opFlags_t   flags
);
  always_comb begin
    flags = '0;
    if (pending) begin
      unique case (opcode)
        OP_PIPE_SEL:  flags.pipeSel  = 1'b1;
        OP_ADAPT_LVL: flags.adaptLvl = 1'b1;
        OP_BL_LVL:    flags.blLvl    = 1'b1;
        default:      flags.unknown  = 1'b1;
      endcase
    end
  end

  always_comb begin
    AST_DECODE_ONEHOT: assert (pending ? $onehot(flags) : (flags == '0)); // R7
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  mbxStrobe_t        strobe,
  input  logic              timeoutFlag,
  input  logic [CNT_W-1:0]  limitReg,
  output logic [7:0]        shOpcode,
  output logic [7:0]        shParam,
  output logic [DATA_W-1:0] shData
);
  logic [DATA_W-1:0] argReg;
  logic [15:0]       cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argReg   <= '0;
      cmdReg   <= '0;
      shOpcode <= '0;
      shParam  <= '0;
      shData   <= '0;
    end else begin
      if (hostWrEn && hostAddr == ADDR_DATA) argReg <= hostWrData;
      if (hostWrEn && hostAddr == ADDR_CMD)  cmdReg <= hostWrData[15:0];
      if (strobe.latchShadow) begin
        shOpcode <= cmdReg[7:0];
        shParam  <= cmdReg[15:8];
        shData   <= argReg;
      end
    end
  end

  always_comb begin
    unique case (hostAddr)
      ADDR_DATA: hostRdData = argReg;
      ADDR_CMD:  hostRdData = DATA_W'(cmdReg);
      ADDR_CTRL: hostRdData = DATA_W'({timeoutFlag, strobe.pending});
      default:   hostRdData = DATA_W'(limitReg);
    endcase
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchShadow |=> ($stable(shData) && $stable(shOpcode) && $stable(shParam))); // R4
  AST_NO_RELATCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pending |-> !strobe.latchShadow); // R5
endmodule

// File: rtl/host_mcu_mailbox.sv
module host_mcu_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int DEF_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              mcuAck,
  output logic              mcuIrq,
  output logic [7:0]        mcuOpcode,
  output logic [7:0]        mcuParam,
  output logic [DATA_W-1:0] mcuData,
  output logic              opPipeSel,
  output logic              opAdaptLevel,
  output logic              opBacklight,
  output logic              opUnknown
);
  mbxStrobe_t       strobe;
  logic             timeoutFlag;
  logic [CNT_W-1:0] limitReg;
  opFlags_t         flags;

  mbx_ctrl #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .wrLow(hostWrData[CNT_W-1:0]), .mcuAck(mcuAck), .strobe(strobe),
    .timeoutFlag(timeoutFlag), .limitReg(limitReg)
  );

  mbx_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .strobe(strobe),
    .timeoutFlag(timeoutFlag), .limitReg(limitReg),
    .shOpcode(mcuOpcode), .shParam(mcuParam), .shData(mcuData)
  );

  mbx_decode dec_i (.opcode(mcuOpcode), .pending(strobe.pending), .flags(flags));

  assign mcuIrq       = strobe.pending;
  assign opPipeSel    = flags.pipeSel;
  assign opAdaptLevel = flags.adaptLvl;
  assign opBacklight  = flags.blLvl;
  assign opUnknown    = flags.unknown;
endmodule

// File: tb/host_mcu_mailbox_tb.sv
module host_mcu_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEF_LIMIT  = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        mcuAck = 1'b0;
  logic        mcuIrq;
  logic [7:0]  mcuOpcode, mcuParam;
  logic [31:0] mcuData;
  logic        opPipeSel, opAdaptLevel, opBacklight, opUnknown;

  int vecCount = 0;
  int failCount = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mcu_mailbox #(.DEF_LIMIT(DEF_LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .mcuAck(mcuAck),
    .mcuIrq(mcuIrq), .mcuOpcode(mcuOpcode), .mcuParam(mcuParam), .mcuData(mcuData),
    .opPipeSel(opPipeSel), .opAdaptLevel(opAdaptLevel), .opBacklight(opBacklight),
    .opUnknown(opUnknown)
  );

  // behavioural reference model
  bit          mBell, mTo;
  int          mCnt;
  int unsigned mLimit;
  logic [31:0] mArg, mData;
  logic [15:0] mCmd, mShCmd;

  always @(posedge clk) begin
    if (!rstN) begin
      mBell = 0; mTo = 0; mCnt = 0; mLimit = DEF_LIMIT;
      mArg = 0; mData = 0; mCmd = 0; mShCmd = 0;
    end else begin
      bit ring;
      ring = hostWrEn && hostAddr == 2 && hostWrData[0] && !mBell;
      if (mBell && mcuAck) mBell = 0;
      else if (ring) begin
        mBell = 1; mTo = 0; mCnt = 0; mShCmd = mCmd; mData = mArg;
      end else if (mBell && mCnt < 65535) begin
        mCnt++;
        if (mLimit != 0 && mCnt == int'(mLimit)) mTo = 1;
      end
      if (hostWrEn) begin
        if (hostAddr == 0) mArg = hostWrData;
        if (hostAddr == 1) mCmd = hostWrData[15:0];
        if (hostAddr == 3) mLimit = hostWrData[15:0];
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mArg;
      2'd1: return {16'h0, mCmd};
      2'd2: return {30'h0, mTo, mBell};
      default: return {16'h0, mLimit[15:0]};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (checking && !done) begin
      logic [3:0] expFlags;
      logic [7:0] op;
      op = mShCmd[7:0];
      expFlags = !mBell ? 4'b0000 :
                 (op == 8'h66) ? 4'b1000 : (op == 8'h65) ? 4'b0100 :
                 (op == 8'h67) ? 4'b0010 : 4'b0001;
      check("R3 R5 R6 irq", 32'(mcuIrq), 32'(mBell));
      check("R4 data", mcuData, mData);
      check("R4 opcode", 32'(mcuOpcode), 32'(mShCmd[7:0]));
      check("R9 param", 32'(mcuParam), 32'(mShCmd[15:8]));
      check("R7 flags", 32'({opPipeSel, opAdaptLevel, opBacklight, opUnknown}), 32'(expFlags));
      check(hostAddr == 2 ? "R3 R8 ctrl read" : "R2 read", hostRdData, modelRead(hostAddr));
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 0;
  endtask

  task automatic ackPulse();
    @(posedge clk); #1; mcuAck = 1;
    @(posedge clk); #1; mcuAck = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string req);
    hostAddr = a;
    @(negedge clk);
    check(req, hostRdData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1; #1;
    // R1 reset state
    peek(2, 32'h0, "R1 ctrl");
    peek(0, 32'h0, "R1 data");
    peek(1, 32'h0, "R1 cmd");
    peek(3, DEF_LIMIT, "R1 limit");
    check("R1 irq/flags", 32'({mcuIrq, opPipeSel, opAdaptLevel, opBacklight, opUnknown}), 32'h0);
    checking = 1;

    // pipe select, param = pipe 2, ramp boundary argument
    hostWrite(3, 32'd20);
    hostWrite(0, 32'h0000_FFFF);
    hostWrite(1, 32'hABCD_0266);
    peek(1, 32'h0000_0266, "R2 cmd upper bits");
    hostWrite(2, 32'h1);
    #0; @(negedge clk);
    check("R3 irq after ring", 32'(mcuIrq), 32'h1);
    check("R9 pipe index", 32'(mcuParam), 32'h2);
    check("R7 pipe flag", 32'(opPipeSel), 32'h1);
    waitCyc(2);
    ackPulse();
    @(negedge clk);
    check("R6 ack clears", 32'(mcuIrq), 32'h0);

    // adaptive level, then busy rewrites
    hostWrite(0, 32'h1234_5678);
    hostWrite(1, 32'h0000_0165);
    hostWrite(2, 32'h1);
    hostWrite(0, 32'hDEAD_BEEF);
    hostWrite(1, 32'h0000_0967);
    hostWrite(2, 32'h1);
    hostWrite(2, 32'h0);
    @(negedge clk);
    check("R5 shadow kept", mcuData, 32'h1234_5678);
    check("R5 still pending", 32'(mcuIrq), 32'h1);
    check("R7 adaptive flag", 32'(opAdaptLevel), 32'h1);
    ackPulse();
    ackPulse();
    @(negedge clk);
    check("R6 idle ack no effect", 32'(mcuIrq), 32'h0);

    // backlight with timeout limit 5
    hostWrite(3, 32'd5);
    hostWrite(1, 32'h0000_0067);
    hostWrite(2, 32'h1);
    waitCyc(3);
    peek(2, 32'h1, "R8 no timeout yet");
    waitCyc(3);
    peek(2, 32'h3, "R8 timeout set");
    check("R7 backlight flag", 32'(opBacklight), 32'h1);
    ackPulse();
    peek(2, 32'h2, "R8 sticky after ack");
    hostWrite(1, 32'h0000_0342);
    hostWrite(3, 32'd0);
    hostWrite(2, 32'h1);
    peek(2, 32'h1, "R8 cleared on ring");
    check("R7 unknown flag", 32'(opUnknown), 32'h1);
    waitCyc(30);
    peek(2, 32'h1, "R8 limit zero disables");
    ackPulse();

    // mixed traffic checked against the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1;
      hostWrEn = ($urandom % 3) == 0;
      hostAddr = 2'($urandom % 4);
      case ($urandom % 5)
        0: hostWrData = 32'h0000_0066 | ((32'($urandom) % 4) << 8);
        1: hostWrData = 32'h0000_0065;
        2: hostWrData = 32'h0000_0067;
        3: hostWrData = 32'($urandom % 9);
        default: hostWrData = 32'($urandom);
      endcase
      mcuAck = ($urandom % 7) == 0;
    end
    @(posedge clk); #1;
    hostWrEn = 0; mcuAck = 0;
    waitCyc(2);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule